// File: doc/BRIEF.md
# Bidirectional Cascadable Column Data Sampler

This block is the input front end of a display column driver. A single token walks through a chain of 70 stages. On each rising clock edge, the stage that holds the token writes one packet into a first-rank line buffer. A packet is six 6-bit colour codes, which is two RGB pixels, and it fills a group of six adjacent output channels. Across all stages that makes 420 channels. The line buffer itself sits outside the block. This block produces the write strobe, the group index and the data word, and the buffer captures them at the same rising edge.

A direction select chooses which way the token walks.
- **Walking upward:** the start pulse arrives on the left cascade pin. Packets fill groups 0, 1, 2 … in order. When the last packet is done, a one-clock pulse leaves on the right pin.
- **Walking downward:** the right pin takes the start pulse, packets fill groups 69, 68 … in order, and the pulse leaves on the left pin.

In both directions the order of codes inside a packet never changes. Two inversion controls each complement one half of the packet before it is stored. A chain of devices passes the pulse from one device to the next, so the whole panel row is filled one device after another.

Top module: `colSampler`

## Requirements
- R1: A token is launched on the clock edge where the selected start pin is high and was low at the previous edge. The selected pin is the left pin when `shiftRight`=1 and the right pin when `shiftRight`=0. A pulse on the other pin launches nothing.
- R2: After a launch, `wrEn` is high for exactly 70 consecutive cycles, starting in the cycle that follows the launch edge. It is low at all other times.
- R3: When launched with `shiftRight`=1, the k-th packet (k = 0…69) is written with `wrGroup` = k. That group holds channels 6k+1 to 6k+6.
- R4: When launched with `shiftRight`=0, the k-th packet is written with `wrGroup` = 69−k.
- R5: Input code i sits at `pixData[6i+5:6i]`, with bit 5 as its MSB. It appears unchanged at `wrData[6i+5:6i]`, which is channel 6·group+i+1, in both directions.
- R6: When `invLow`=1, codes 0, 1 and 2 are bitwise complemented before they are written (for example 00→3F and 07→38). Codes 3 to 5 are not affected.
- R7: When `invHigh`=1, codes 3, 4 and 5 are bitwise complemented. Codes 0 to 2 are not affected.
- R8: In the cycle after the 70th write, the far pin drives a high pulse that lasts exactly one clock. The far pin is the right pin for an upward walk and the left pin for a downward walk. The near pin output stays low.
- R9: `dioLeftOe` equals the inverse of `shiftRight`, and `dioRightOe` equals `shiftRight`.
- R10: A start pin that stays high for several cycles launches only one token. A new rising edge on the start pin while the block is busy is ignored.
- R11: `busy` is high from the cycle after the launch edge through the cascade-pulse cycle, and low in the cycle after that.
- R12: After reset, `wrEn`, `busy`, `dioLeftOut` and `dioRightOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| shiftRight | input | 1 | 1: walk upward (start on left pin), 0: walk downward (start on right pin) |
| dioLeftIn | input | 1 | Level seen on the left cascade pin |
| dioLeftOut | output | 1 | Cascade pulse driven onto the left pin |
| dioLeftOe | output | 1 | Output enable for the left pin |
| dioRightIn | input | 1 | Level seen on the right cascade pin |
| dioRightOut | output | 1 | Cascade pulse driven onto the right pin |
| dioRightOe | output | 1 | Output enable for the right pin |
| pixData | input | 36 | Six 6-bit codes; code i in bits 6i+5:6i |
| invLow | input | 1 | Complement codes 0 to 2 |
| invHigh | input | 1 | Complement codes 3 to 5 |
| wrEn | output | 1 | Line buffer write strobe |
| wrGroup | output | 7 | Six-channel group being written (0 to 69) |
| wrData | output | 36 | Packet to store, after inversion |
| busy | output | 1 | Token or cascade pulse in flight |

## Verification
The start edge is registered, so the launch edge itself produces no write. The write outputs are combinational from the token register, which means the packet for step k is visible in the cycle after launch edge t+k. The bench therefore drives that packet at the preceding falling edge and compares it 3 ns later, well before the capture edge. The cascade pulse must appear one cycle after the 70th write, and `busy` must fall one cycle after that pulse. The driver samples both of these at the following two falling edges. Every expected write is pushed to a queue before the cycle in which it is due. The monitor reports a write that arrives with an empty queue as a failure, and at the end of each run it reports any entry left unpopped.

// File: rtl/colSamplerPkg.sv
package colSamplerPkg;
  // Strobes the control path hands to the datapath each cycle
  typedef struct packed {
    logic launch;    // token launched at this edge
    logic capture;   // a stage holds the token: write this cycle
    logic dirRight;  // direction latched at launch
    logic cascade;   // far-pin pulse cycle
  } ctrlStrobeT;
endpackage

// File: rtl/colSamplerCtrl.sv
module colSamplerCtrl
  import colSamplerPkg::*;
#(
  parameter int STAGES = 70,
  localparam int IDX_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftRight,
  input  logic             startLeft,
  input  logic             startRight,
  output ctrlStrobeT       strobes,
  output logic [IDX_W-1:0] stageIdx,
  output logic             busy
);
  logic              startSel, startPrev, launch;
  logic [STAGES-1:0] token;
  logic              dirLat, casPulse;

  assign startSel = shiftRight ? startLeft : startRight;
  assign busy     = (|token) | casPulse;
  assign launch   = startSel & ~startPrev & ~busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPrev <= 1'b0;
      token     <= '0;
      dirLat    <= 1'b1;
      casPulse  <= 1'b0;
    end else begin
      startPrev <= startSel;
      token     <= {token[STAGES-2:0], launch};
      casPulse  <= token[STAGES-1];
      if (launch) dirLat <= shiftRight;
    end
  end

  always_comb begin
    stageIdx = '0;
    for (int i = 0; i < STAGES; i++)
      if (token[i]) stageIdx = IDX_W'(i);
  end

  assign strobes.launch   = launch;
  assign strobes.capture  = |token;
  assign strobes.dirRight = dirLat;
  assign strobes.cascade  = casPulse;

  p_token_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(token));
  p_pulse_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    token[STAGES-1] |=> casPulse);
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    casPulse |=> !casPulse);
  p_launch_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> busy);
  p_one_token_r10: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !launch);
endmodule

// File: rtl/colSamplerDpath.sv
module colSamplerDpath
  import colSamplerPkg::*;
#(
  parameter int STAGES = 70,
  parameter int CODES  = 6,
  parameter int CODE_W = 6,
  localparam int IDX_W  = $clog2(STAGES),
  localparam int PKT_W  = CODES * CODE_W,
  localparam int HALF   = CODES / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic [IDX_W-1:0] stageIdx,
  input  logic [PKT_W-1:0] pixData,
  input  logic             invLow,
  input  logic             invHigh,
  output logic             wrEn,
  output logic [IDX_W-1:0] wrGroup,
  output logic [PKT_W-1:0] wrData
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(STAGES - 1);

  assign wrEn    = strobes.capture;
  assign wrGroup = strobes.dirRight ? stageIdx : (LAST - stageIdx);

  for (genvar i = 0; i < CODES; i++) begin : g_code
    logic flip;
    if (i < HALF) begin : g_lo
      assign flip = invLow;
    end else begin : g_hi
      assign flip = invHigh;
    end
    assign wrData[i*CODE_W +: CODE_W] =
      pixData[i*CODE_W +: CODE_W] ^ {CODE_W{flip}};
  end

  p_group_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrGroup <= LAST);
  p_group_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !strobes.cascade && $past(wrEn) && !strobes.dirRight)
      |-> wrGroup == $past(wrGroup) - 1'b1);
endmodule

// File: rtl/colSampler.sv
module colSampler
  import colSamplerPkg::*;
#(
  parameter int STAGES = 70,
  parameter int CODES  = 6,
  parameter int CODE_W = 6,
  localparam int IDX_W = $clog2(STAGES),
  localparam int PKT_W = CODES * CODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftRight,
  input  logic             dioLeftIn,
  output logic             dioLeftOut,
  output logic             dioLeftOe,
  input  logic             dioRightIn,
  output logic             dioRightOut,
  output logic             dioRightOe,
  input  logic [PKT_W-1:0] pixData,
  input  logic             invLow,
  input  logic             invHigh,
  output logic             wrEn,
  output logic [IDX_W-1:0] wrGroup,
  output logic [PKT_W-1:0] wrData,
  output logic             busy
);
  ctrlStrobeT       strobes;
  logic [IDX_W-1:0] stageIdx;

  colSamplerCtrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .shiftRight(shiftRight),
    .startLeft(dioLeftIn), .startRight(dioRightIn),
    .strobes(strobes), .stageIdx(stageIdx), .busy(busy));

  colSamplerDpath #(.STAGES(STAGES), .CODES(CODES), .CODE_W(CODE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .stageIdx(stageIdx),
    .pixData(pixData), .invLow(invLow), .invHigh(invHigh),
    .wrEn(wrEn), .wrGroup(wrGroup), .wrData(wrData));

  assign dioRightOut = strobes.cascade &  strobes.dirRight;
  assign dioLeftOut  = strobes.cascade & ~strobes.dirRight;
  assign dioRightOe  = shiftRight;
  assign dioLeftOe   = ~shiftRight;

  p_oe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(dioLeftOe && dioRightOe));
  p_out_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(dioLeftOut && dioRightOut));
  p_no_write_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dioLeftOut || dioRightOut) |-> !wrEn);
endmodule

// File: tb/tb_colSampler.sv
module tb_colSampler;
  localparam int STAGES = 70;
  localparam int PKT_W  = 36;

  logic clk = 1'b0, rstN = 1'b0, shiftRight = 1'b1;
  logic dioLeftIn = 1'b0, dioRightIn = 1'b0, invLow = 1'b0, invHigh = 1'b0;
  logic [PKT_W-1:0] pixData = '0;
  logic dioLeftOut, dioLeftOe, dioRightOut, dioRightOe, wrEn, busy;
  logic [6:0] wrGroup;
  logic [PKT_W-1:0] wrData;

  int errors = 0, checks = 0;
  logic [6+PKT_W:0] expQ[$];

  always #5 clk = ~clk;

  colSampler dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each write
  initial forever begin
    @(negedge clk); #3;
    if (rstN && wrEn) begin
      if (expQ.size() == 0) chk(1'b0, "R2 unexpected write", wrGroup, 0);
      else begin
        logic [6+PKT_W:0] e;
        e = expQ.pop_front();
        chk(wrGroup == e[6+PKT_W:PKT_W], "R3/R4 group", wrGroup, e[6+PKT_W:PKT_W]);
        chk(wrData == e[PKT_W-1:0], "R5/R6/R7 data", wrData, e[PKT_W-1:0]);
      end
    end
  end

  function automatic logic [PKT_W-1:0] mkPkt(int seed, int k);
    logic [PKT_W-1:0] p;
    for (int i = 0; i < 6; i++) p[i*6 +: 6] = 6'((seed + k*5 + i*13) & 63);
    return p;
  endfunction

  // one full run: glitch re-pulses start during the walk (R10)
  task automatic runWalk(bit dirR, bit iL, bit iH, int hold, bit glitch, int seed);
    logic [PKT_W-1:0] p, e;
    @(negedge clk);
    shiftRight = dirR; invLow = iL; invHigh = iH;
    if (dirR) dioLeftIn = 1'b1; else dioRightIn = 1'b1;
    @(posedge clk);
    for (int k = 0; k < STAGES; k++) begin
      @(negedge clk);
      p = mkPkt(seed, k);
      pixData = p;
      if (k == hold) begin dioLeftIn = 1'b0; dioRightIn = 1'b0; end
      if (glitch && k == 20) begin
        if (dirR) dioLeftIn = 1'b1; else dioRightIn = 1'b1;
      end
      if (glitch && k == 23) begin dioLeftIn = 1'b0; dioRightIn = 1'b0; end
      e = p;
      for (int i = 0; i < 6; i++)
        if ((i < 3 && iL) || (i >= 3 && iH)) e[i*6 +: 6] = ~p[i*6 +: 6];
      expQ.push_back({7'(dirR ? k : STAGES-1-k), e});
      #3;
      if (k == 0) chk(busy == 1'b1, "R11 busy after launch", busy, 1);
      if (k == 0) begin
        chk(dioLeftOe == !dirR, "R9 left oe", dioLeftOe, !dirR);
        chk(dioRightOe == dirR, "R9 right oe", dioRightOe, dirR);
      end
    end
    @(negedge clk); #3;
    chk((dirR ? dioRightOut : dioLeftOut) == 1'b1, "R8 far pulse", dirR ? dioRightOut : dioLeftOut, 1);
    chk((dirR ? dioLeftOut : dioRightOut) == 1'b0, "R8 near quiet", dirR ? dioLeftOut : dioRightOut, 0);
    chk(wrEn == 1'b0, "R2 no write in pulse cycle", wrEn, 0);
    chk(busy == 1'b1, "R11 busy in pulse cycle", busy, 1);
    @(negedge clk); #3;
    chk(dioRightOut == 1'b0 && dioLeftOut == 1'b0, "R8 pulse one clock", {dioLeftOut, dioRightOut}, 0);
    chk(busy == 1'b0, "R11 busy low after pulse", busy, 0);
    chk(expQ.size() == 0, "R2 all writes seen", expQ.size(), 0);
    dioLeftIn = 1'b0; dioRightIn = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk(wrEn == 1'b0 && busy == 1'b0, "R10 no second token", {wrEn, busy}, 0);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #3;
    chk(wrEn == 1'b0 && busy == 1'b0 && dioLeftOut == 1'b0 && dioRightOut == 1'b0,
        "R12 reset state", {wrEn, busy, dioLeftOut, dioRightOut}, 0);
    @(negedge clk); rstN = 1'b1;
    // R1: pulse on the wrong pin while walking upward
    @(negedge clk); shiftRight = 1'b1; dioRightIn = 1'b1;
    repeat (3) @(negedge clk);
    dioRightIn = 1'b0; #3;
    chk(busy == 1'b0 && wrEn == 1'b0, "R1 wrong pin ignored", {busy, wrEn}, 0);
    runWalk(1'b1, 1'b0, 1'b0, 0,  1'b0, 3);   // R3 R5
    runWalk(1'b0, 1'b0, 1'b0, 0,  1'b0, 9);   // R4 R5
    runWalk(1'b1, 1'b1, 1'b0, 5,  1'b0, 17);  // R6, long start R10
    runWalk(1'b0, 1'b0, 1'b1, 0,  1'b1, 40);  // R7, re-pulse R10
    runWalk(1'b1, 1'b1, 1'b1, 70, 1'b0, 0);   // both halves, start held through
    // R1: pulse on the left pin while walking downward
    @(negedge clk); shiftRight = 1'b0; dioLeftIn = 1'b1;
    repeat (3) @(negedge clk);
    dioLeftIn = 1'b0; #3;
    chk(busy == 1'b0 && wrEn == 1'b0, "R1 wrong pin ignored down", {busy, wrEn}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule